// File: doc/BRIEF.md
# Staged Word Memory Access Unit

This block connects a processor control path to a private array of 16-bit words. Every transfer passes through two staging registers: an address stage register that selects a word, and a data stage register that holds the word being moved. The controller fills these registers one step at a time, using separate load strobes and one shared input bus, and then issues a read or write command. The array has a latency set by a parameter, so the command takes that many cycles. A one-cycle ready pulse tells the controller that the access has finished.

A load takes three steps. The controller strobes the address in, issues a read, waits for ready and then takes the word from the data stage register. A store also takes three steps. The controller strobes the word into the data stage register, strobes the address in and issues a write. The array changes when the access completes. While an access is pending, the unit ignores any further command. Each address selects one whole word, and there is no byte selection.

Top module: `mem_stage_unit`

## Requirements
- R1: When reset is high at a clock edge, the address stage register and the data stage register both become zero, ready becomes low, and any pending access is dropped.
- R2: When `ld_addr` is high at an edge, the address stage register takes the low ADDR_W bits of `bus_in`. When it is low, the register holds its value.
- R3: When `ld_data` is high at an edge, the data stage register is loaded. It takes `bus_in` when `data_sel` is 0, and it takes the array word at the current address when `data_sel` is 1. When `ld_data` is low, the register holds its value, except when a read completes.
- R4: If the unit is idle, a read command given at edge E completes at edge E+LATENCY. At that edge, the data stage register takes the array word at the address stage register. `ready` is high for the cycle that follows.
- R5: If the unit is idle, a write command given at edge E completes at edge E+LATENCY. At that edge, the array word at the address stage register takes the value of the data stage register. A later read of that address returns the new value.
- R6: `ready` is high for exactly one cycle for each accepted command and is low at every other time.
- R7: A read or write command given while an access is pending is ignored, including at the completion edge. It does not shift the timing of `ready`, it does not add a second pulse, and it does not change the array.
- R8: If read and write are both high at an idle edge, the access is a read. The array is not written.
- R9: At a read completion edge, the array word goes into the data stage register even if `ld_data` is high at that same edge.
- R10: Each address selects its own full word. A write to one address leaves every other address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_addr | input | 1 | Load strobe for the address stage register |
| ld_data | input | 1 | Load strobe for the data stage register |
| data_sel | input | 1 | Source for the data stage register load: 0 selects bus_in, 1 selects the array word |
| bus_in | input | DATA_W | Processor bus value |
| rd_cmd | input | 1 | Read command |
| wr_cmd | input | 1 | Write command |
| mar_q | output | ADDR_W | Address stage register |
| mdr_q | output | DATA_W | Data stage register |
| ready | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the unit with ADDR_W=4 and LATENCY=3. A sixteen-word array lets random traffic revisit every location many times, so a write that disturbs a neighbouring word shows up on a later read. A latency of three leaves two cycles in the middle of each access and one completion edge. On each of these, the bench can issue colliding commands and strobes, which covers both the ignored-command rule and the read-over-strobe priority.

// File: rtl/msu_pkg.sv
package msu_pkg;

    // Source chosen for a data stage register load
    typedef enum logic {
        MDR_FROM_BUS = 1'b0,
        MDR_FROM_MEM = 1'b1
    } mdr_src_e;

    // Kind of access held by the sequencer
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    // Completion events handed from the sequencer to the datapath
    typedef struct packed {
        logic fire_rd;
        logic fire_wr;
    } acc_done_t;

    // Read wins when both commands arrive together
    function automatic acc_kind_e pick_kind(input logic rd, input logic wr);
        if (rd)      return ACC_READ;
        else if (wr) return ACC_WRITE;
        else         return ACC_IDLE;
    endfunction

endpackage

// File: rtl/msu_word_array.sv
module msu_word_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Writes are clocked; the read port presents the addressed word
    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/msu_sequencer.sv
module msu_sequencer
    import msu_pkg::*;
#(
    parameter int LATENCY = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rd_cmd,
    input  logic      wr_cmd,
    output acc_done_t done,
    output logic      ready
);
    localparam int CW = (LATENCY < 2) ? 1 : $clog2(LATENCY + 1);
    localparam logic [CW-1:0] START = CW'(LATENCY - 1);

    logic          busy;
    acc_kind_e     kind;
    logic [CW-1:0] remain;
    logic          finish;

    assign finish       = busy && (remain == '0);
    assign done.fire_rd = finish && (kind == ACC_READ);
    assign done.fire_wr = finish && (kind == ACC_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            kind   <= ACC_IDLE;
            remain <= '0;
            ready  <= 1'b0;
        end else begin
            ready <= finish;
            if (busy) begin
                // commands arriving now are dropped
                if (finish) begin
                    busy <= 1'b0;
                    kind <= ACC_IDLE;
                end else begin
                    remain <= remain - 1'b1;
                end
            end else if (rd_cmd || wr_cmd) begin
                busy   <= 1'b1;
                kind   <= pick_kind(rd_cmd, wr_cmd);
                remain <= START;
            end
        end
    end

endmodule

// File: rtl/msu_stage_regs.sv
module msu_stage_regs
    import msu_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_addr,
    input  logic              ld_data,
    input  mdr_src_e          src,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              rd_fire,
    input  logic [DATA_W-1:0] mem_word,
    output logic [ADDR_W-1:0] mar_q,
    output logic [DATA_W-1:0] mdr_q
);
    logic [DATA_W-1:0] mdr_nxt;

    always_comb begin
        mdr_nxt = mdr_q;
        if (rd_fire)
            mdr_nxt = mem_word;
        else if (ld_data)
            mdr_nxt = (src == MDR_FROM_MEM) ? mem_word : bus_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q <= '0;
            mdr_q <= '0;
        end else begin
            if (ld_addr) mar_q <= bus_in[ADDR_W-1:0];
            mdr_q <= mdr_nxt;
        end
    end

endmodule

// File: rtl/mem_stage_unit.sv
module mem_stage_unit
    import msu_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int LATENCY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_addr,
    input  logic              ld_data,
    input  logic              data_sel,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              rd_cmd,
    input  logic              wr_cmd,
    output logic [ADDR_W-1:0] mar_q,
    output logic [DATA_W-1:0] mdr_q,
    output logic              ready
);
    acc_done_t         done;
    logic [DATA_W-1:0] mem_word;
    mdr_src_e          src;

    assign src = mdr_src_e'(data_sel);

    msu_sequencer #(.LATENCY(LATENCY)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .rd_cmd (rd_cmd),
        .wr_cmd (wr_cmd),
        .done   (done),
        .ready  (ready)
    );

    msu_stage_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .ld_addr  (ld_addr),
        .ld_data  (ld_data),
        .src      (src),
        .bus_in   (bus_in),
        .rd_fire  (done.fire_rd),
        .mem_word (mem_word),
        .mar_q    (mar_q),
        .mdr_q    (mdr_q)
    );

    msu_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (done.fire_wr),
        .addr  (mar_q),
        .wdata (mdr_q),
        .rdata (mem_word)
    );

endmodule

// File: rtl/msu_chk.sv
module msu_chk #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int LATENCY = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              ld_addr,
    input logic              ld_data,
    input logic [DATA_W-1:0] bus_in,
    input logic              rd_cmd,
    input logic              wr_cmd,
    input logic [ADDR_W-1:0] mar_q,
    input logic [DATA_W-1:0] mdr_q,
    input logic              ready
);
    // Independent tracker of an accepted access, counting edges up
    logic shadow_busy;
    int   shadow_cnt;
    logic shadow_end;

    assign shadow_end = shadow_busy && (shadow_cnt == LATENCY);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_busy <= 1'b0;
            shadow_cnt  <= 0;
        end else if (shadow_busy) begin
            if (shadow_end) shadow_busy <= 1'b0;
            else            shadow_cnt  <= shadow_cnt + 1;
        end else if (rd_cmd || wr_cmd) begin
            shadow_busy <= 1'b1;
            shadow_cnt  <= 1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mar_q == '0 && mdr_q == '0 && !ready));

    // R2
    mar_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_addr |=> $stable(mar_q));

    // R2
    mar_load_chk: assert property (@(posedge clk) disable iff (rst)
        ld_addr |=> (mar_q == $past(bus_in[ADDR_W-1:0])));

    // R3
    mdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_data |=> ($stable(mdr_q) || ready));

    // R4
    ready_on_time_chk: assert property (@(posedge clk) disable iff (rst)
        shadow_end |=> ready);

    // R7
    no_stray_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> $past(shadow_end));

    // R6
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

endmodule

bind mem_stage_unit msu_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .LATENCY (LATENCY)
) u_msu_chk (
    .clk     (clk),
    .rst     (rst),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .bus_in  (bus_in),
    .rd_cmd  (rd_cmd),
    .wr_cmd  (wr_cmd),
    .mar_q   (mar_q),
    .mdr_q   (mdr_q),
    .ready   (ready)
);

// File: tb/mem_stage_unit_bench.sv
module mem_stage_unit_bench;
    localparam int AW    = 4;
    localparam int DW    = 16;
    localparam int LAT   = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_addr = 1'b0, ld_data = 1'b0, data_sel = 1'b0;
    logic [DW-1:0] bus_in = '0;
    logic          rd_cmd = 1'b0, wr_cmd = 1'b0;
    logic [AW-1:0] mar_q;
    logic [DW-1:0] mdr_q;
    logic          ready;

    always #4 clk = ~clk;

    mem_stage_unit #(.ADDR_W(AW), .DATA_W(DW), .LATENCY(LAT)) u_mem_stage_unit (
        .clk(clk), .rst(rst), .ld_addr(ld_addr), .ld_data(ld_data),
        .data_sel(data_sel), .bus_in(bus_in), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
        .mar_q(mar_q), .mdr_q(mdr_q), .ready(ready)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference state, built from the requirements
    logic [DW-1:0] m_mem [DEPTH];
    logic [AW-1:0] m_mar;
    logic [DW-1:0] m_mdr;
    logic          m_ready, m_busy, m_isrd, m_rdfin;
    int            m_cnt;
    int            ready_seen;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mar = '0; m_mdr = '0; m_ready = 1'b0; m_busy = 1'b0;
        m_isrd = 1'b0; m_cnt = 0; m_rdfin = 1'b0;
    endtask

    task automatic model_edge();
        logic          fin;
        logic [DW-1:0] word;
        fin  = m_busy && (m_cnt == LAT);
        word = m_mem[m_mar];
        m_rdfin = fin && m_isrd;
        if (fin && !m_isrd) m_mem[m_mar] = m_mdr;
        if (fin && m_isrd)  m_mdr = word;
        else if (ld_data)   m_mdr = data_sel ? word : bus_in;
        if (ld_addr) m_mar = bus_in[AW-1:0];
        m_ready = fin;
        if (m_busy) begin
            if (fin) m_busy = 1'b0;
            else     m_cnt++;
        end else if (rd_cmd || wr_cmd) begin
            m_busy = 1'b1; m_cnt = 1; m_isrd = rd_cmd;
        end
    endtask

    task automatic step(input bit la, input bit ld, input bit sel,
                        input logic [DW-1:0] b, input bit r, input bit w);
        ld_addr = la; ld_data = ld; data_sel = sel; bus_in = b; rd_cmd = r; wr_cmd = w;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (ready) ready_seen++;
        chk("R6 ready", ready, m_ready);
        chk("R2 mar", mar_q, m_mar);
        chk(m_rdfin ? "R4 mdr after read" : "R3 mdr", mdr_q, m_mdr);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0, 0);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        step(0, 1, 0, d, 0, 0);
        step(1, 0, 0, DW'(a), 0, 0);
        step(0, 0, 0, '0, 0, 1);
        idle(LAT);
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        step(1, 0, 0, DW'(a), 0, 0);
        step(0, 0, 0, '0, 1, 0);
        idle(LAT - 1);
        chk("R4 ready low before completion", ready, 1'b0);
        idle(1);
        chk("R4 ready at completion", ready, 1'b1);
        d = mdr_q;
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] got, keep;
        logic [AW-1:0] a;
        void'($urandom(32'd2718));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R1: state right after reset
        chk("R1 mar after reset", mar_q, '0);
        chk("R1 mdr after reset", mdr_q, '0);
        chk("R1 ready after reset", ready, 1'b0);

        // R5 / R10: fill every word, then read each back
        for (int i = 0; i < DEPTH; i++) do_write(AW'(i), DW'(16'hA500 + i * 16'h0111));
        for (int i = 0; i < DEPTH; i++) begin
            do_read(AW'(i), got);
            chk("R10 distinct word", got, DW'(16'hA500 + i * 16'h0111));
        end
        do_write(4'd5, 16'h5A5A);
        do_read(4'd5, got);
        chk("R5 write visible", got, 16'h5A5A);
        do_read(4'd6, got);
        chk("R10 neighbour intact", got, m_mem[6]);

        // R3: load data stage register from the array word
        step(1, 0, 0, 16'd9, 0, 0);
        step(0, 1, 1, 16'hFFFF, 0, 0);
        chk("R3 mdr from array", mdr_q, m_mem[9]);

        // R7: commands during a pending read, including its completion edge
        keep = m_mem[3];
        step(0, 1, 0, 16'h0BAD, 0, 0);
        step(1, 0, 0, 16'd3, 0, 0);
        ready_seen = 0;
        step(0, 0, 0, '0, 1, 0);
        for (int i = 0; i < LAT; i++) step(0, 0, 0, '0, 1, 1);
        chk("R7 single ready", ready_seen, 1);
        chk("R7 read data", mdr_q, keep);
        idle(1);
        do_read(4'd3, got);
        chk("R7 array unchanged", got, keep);

        // R8: simultaneous read and write acts as read
        keep = m_mem[7];
        step(0, 1, 0, 16'hBEEF, 0, 0);
        step(1, 0, 0, 16'd7, 0, 0);
        step(0, 0, 0, '0, 1, 1);
        idle(LAT);
        chk("R8 read taken", mdr_q, keep);
        do_read(4'd7, got);
        chk("R8 no write", got, keep);

        // R9: strobe at the read completion edge loses to the array word
        step(1, 0, 0, 16'd2, 0, 0);
        step(0, 0, 0, '0, 1, 0);
        idle(LAT - 1);
        step(0, 1, 0, 16'h1111, 0, 0);
        chk("R9 read beats strobe", mdr_q, m_mem[2]);

        // Random traffic against the reference
        for (int i = 0; i < 4000; i++)
            step(($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 2) == 1,
                 DW'($urandom), ($urandom % 6) == 0, ($urandom % 7) == 0);
        idle(LAT + 1);
        for (int i = 0; i < DEPTH; i++) begin
            a = AW'(i);
            do_read(a, got);
            chk("R10 final contents", got, m_mem[i]);
        end

        // R1: reset in the middle of an access drops it
        step(0, 0, 0, '0, 1, 0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        ready_seen = 0;
        idle(LAT + 2);
        chk("R1 access dropped", ready_seen, 0);
        chk("R1 mdr cleared", mdr_q, '0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule